// File: doc/BRIEF.md
# Configurable CRC Accelerator

The block is a register-mapped CRC engine on a plain 32-bit bus with a write strobe, a read strobe and per-lane byte enables. Software writes data words, halfwords or bytes into a data register. Each write can be reordered at byte level and have the bits of each byte mirrored. It is then folded into a running checksum in one clock, with the higher byte lane taken first.

Two polynomials are available. One is a fixed 32-bit generator, 0x04C11DB7. The other is a 16-bit generator that software loads into a polynomial register. The running value can be read in three forms: as is, bit-mirrored, or byte-swapped. The engine can be seeded to all zeros or all ones from the control word. When automatic seeding is armed, it also reseeds itself after a read of a chosen byte of any result form.

Two aliases of the control word let software set or clear individual bits without a read-modify-write. Register accesses complete in the cycle they are presented. Read data is combinational from the current state. A reseed triggered by a read takes effect at the end of that read cycle.

Top module: `crc_accel`

## Requirements
- R1: The control word keeps only bits 1, 2, 4, 8, 9, 11:10, 13 and 14 (mask 0x6F16). All other bits, bit 0 included, read as zero. A write to offset 0x04 ORs the masked data into the word. A write to offset 0x08 clears every bit that is one in the data.
- R2: A write to offset 0x00 or 0x04 with data bit 0 set loads the checksum in that same cycle. The value loaded is all ones when the resulting control bit 1 is 1, and all zeros when it is 0.
- R3: With control bit 4 at 0, each byte is folded MSB-first, without reflection and without a final XOR, using polynomial 0x04C11DB7. Seeded with all ones, the nine bytes "123456789" give 0x0376E6E7.
- R4: With control bit 4 at 1, each byte is folded into a 16-bit checksum using polynomial register bits 15:0 (offset 0x10). Result bits 31:16 read as zero. With generator 0x1021 and an all-ones seed, "123456789" gives 0x29B1.
- R5: With byte mode off, the byte enables set the width of a data write. 1111 folds four bytes, lane 3 first. 0011 and 1100 fold that halfword, high lane first. A single set enable folds that one lane. Any other pattern, and 0000, leaves the checksum unchanged.
- R6: With control bit 8 set, every data write folds exactly one byte, bus bits 7:0, after optional bit mirroring. Reordering is not applied and the byte enables are not used.
- R7: Control bits 11:10 reorder the bus word before lanes are picked. Code 0 and code 3 keep it as is. Code 1 maps B3 B2 B1 B0 to B2 B3 B0 B1. Code 2 maps B3 B2 B1 B0 to B0 B1 B2 B3.
- R8: With control bit 9 set, the bit order inside each byte of the reordered word is reversed before folding.
- R9: While control bit 2 is 0, writes to the data register leave the checksum unchanged.
- R10: Offset 0x30 returns the checksum with its bits mirrored over 32 bits, or over 16 bits in 16-bit mode. Offset 0x40 returns it with its bytes swapped over 4 bytes, or over 2 bytes in 16-bit mode.
- R11: With control bit 13 set, a read of offset 0x20, 0x30 or 0x40 whose byte enable covers the selected lane returns the current value and then reseeds the checksum with the value given by control bit 1. Control bit 14 selects the lane. At 0 it is lane 0. At 1 it is lane 3 in 32-bit mode and lane 1 in 16-bit mode.
- R12: Reads at 0x00, 0x04 and 0x08 return the control word, 0x10 returns the polynomial in bits 15:0, and 0x20 returns the checksum. Any other offset, including an unaligned one, reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_rd | input | 1 | Read strobe for the current access |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables, bit n covers bits 8n+7:8n |
| bus_rdata | output | 32 | Read data for the presented address |

## Verification
The bench builds the block with its default parameters: an 8-bit address and the generator 0x04C11DB7. This puts the full register map within reach, and both well-known check strings for the 32-bit and 16-bit generators can be compared against published constants. A behavioural model in the bench folds one bit at a time and shapes its input with index arithmetic. It predicts the result forms after every access, across every reorder code, the halfword and odd-enable writes, byte mode, and both automatic-seed lane choices in each width.

// File: rtl/crc_accel_pkg.sv
package crc_accel_pkg;

    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;
    localparam int HALF_W   = 16;
    localparam int CNT_W    = $clog2(LANES + 1);

    // register offsets
    localparam int OFF_CTRL = 'h00;
    localparam int OFF_SET  = 'h04;
    localparam int OFF_CLR  = 'h08;
    localparam int OFF_POLY = 'h10;
    localparam int OFF_DATA = 'h20;
    localparam int OFF_REV  = 'h30;
    localparam int OFF_SWAP = 'h40;

    // control word bit positions
    localparam int CB_SEED_GO  = 0;
    localparam int CB_SEED_ONE = 1;
    localparam int CB_ENABLE   = 2;
    localparam int CB_NARROW   = 4;
    localparam int CB_BYTEMODE = 8;
    localparam int CB_MIRROR   = 9;
    localparam int CB_ORD_LO   = 10;
    localparam int CB_AUTO     = 13;
    localparam int CB_AUTO_HI  = 14;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_6F16;

    typedef enum logic [1:0] {
        ORD_KEEP      = 2'd0,
        ORD_HALF_SWAP = 2'd1,
        ORD_FULL_SWAP = 2'd2,
        ORD_KEEP_ALT  = 2'd3
    } order_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_SET,
        ACC_CLR,
        ACC_POLY,
        ACC_DATA,
        ACC_REV,
        ACC_SWAP
    } acc_e;

    function automatic logic [7:0] mirror8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] step32(input logic [DATA_W-1:0] c,
                                                 input logic [7:0] d,
                                                 input logic [DATA_W-1:0] g);
        logic [DATA_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[DATA_W-1] ^ d[i];
            r  = {r[DATA_W-2:0], 1'b0} ^ (fb ? g : '0);
        end
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] step16(input logic [HALF_W-1:0] c,
                                                 input logic [7:0] d,
                                                 input logic [HALF_W-1:0] g);
        logic [HALF_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[HALF_W-1] ^ d[i];
            r  = {r[HALF_W-2:0], 1'b0} ^ (fb ? g : '0);
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_input_shaper.sv
module crc_input_shaper
    import crc_accel_pkg::*;
(
    input  logic [DATA_W-1:0]           wdata,
    input  logic [LANES-1:0]            be,
    input  logic [1:0]                  order,
    input  logic                        mirror,
    input  logic                        byte_mode,
    output logic [LANES-1:0][7:0]       seq,
    output logic [CNT_W-1:0]            count
);

    logic [LANES-1:0][7:0] raw;
    logic [LANES-1:0][7:0] ordered;
    logic [LANES-1:0][7:0] shaped;

    assign raw = wdata;

    always_comb begin
        ordered = raw;
        unique case (order_e'(order))
            ORD_HALF_SWAP: for (int i = 0; i < LANES; i++) ordered[i] = raw[i ^ 1];
            ORD_FULL_SWAP: for (int i = 0; i < LANES; i++) ordered[i] = raw[LANES-1-i];
            ORD_KEEP, ORD_KEEP_ALT: ordered = raw;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_mirror
        assign shaped[g] = mirror ? mirror8(ordered[g]) : ordered[g];
    end

    // seq[0] is folded first
    always_comb begin
        seq   = '0;
        count = '0;
        if (byte_mode) begin
            seq[0] = mirror ? mirror8(raw[0]) : raw[0];
            count  = CNT_W'(1);
        end else begin
            unique case (be)
                4'b1111: begin
                    for (int i = 0; i < LANES; i++) seq[i] = shaped[LANES-1-i];
                    count = CNT_W'(LANES);
                end
                4'b0011: begin seq[0] = shaped[1]; seq[1] = shaped[0]; count = CNT_W'(2); end
                4'b1100: begin seq[0] = shaped[3]; seq[1] = shaped[2]; count = CNT_W'(2); end
                4'b0001: begin seq[0] = shaped[0]; count = CNT_W'(1); end
                4'b0010: begin seq[0] = shaped[1]; count = CNT_W'(1); end
                4'b0100: begin seq[0] = shaped[2]; count = CNT_W'(1); end
                4'b1000: begin seq[0] = shaped[3]; count = CNT_W'(1); end
                default: count = '0;
            endcase
        end
    end

endmodule

// File: rtl/crc_fold.sv
module crc_fold
    import crc_accel_pkg::*;
#(
    parameter logic [DATA_W-1:0] POLY32 = 32'h04C1_1DB7
) (
    input  logic [DATA_W-1:0]           crc_in,
    input  logic [LANES-1:0][7:0]       seq,
    input  logic [CNT_W-1:0]            count,
    input  logic [HALF_W-1:0]           poly16,
    input  logic                        narrow,
    output logic [DATA_W-1:0]           crc_out
);

    logic [LANES:0][DATA_W-1:0] stage;

    assign stage[0] = crc_in;

    for (genvar i = 0; i < LANES; i++) begin : g_stage
        logic [DATA_W-1:0] stepped;
        always_comb begin
            if (narrow)
                stepped = {{(DATA_W-HALF_W){1'b0}}, step16(stage[i][HALF_W-1:0], seq[i], poly16)};
            else
                stepped = step32(stage[i], seq[i], POLY32);
        end
        assign stage[i+1] = (CNT_W'(i) < count) ? stepped : stage[i];
    end

    assign crc_out = stage[LANES];

endmodule

// File: rtl/crc_views.sv
module crc_views
    import crc_accel_pkg::*;
(
    input  logic [DATA_W-1:0] crc,
    input  logic              narrow,
    output logic [DATA_W-1:0] plain_view,
    output logic [DATA_W-1:0] mirror_view,
    output logic [DATA_W-1:0] swap_view
);

    logic [DATA_W-1:0] mir_full;
    logic [HALF_W-1:0] mir_half;
    logic [DATA_W-1:0] swp_full;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mir_full
        assign mir_full[i] = crc[DATA_W-1-i];
    end
    for (genvar i = 0; i < HALF_W; i++) begin : g_mir_half
        assign mir_half[i] = crc[HALF_W-1-i];
    end
    for (genvar b = 0; b < LANES; b++) begin : g_swap
        assign swp_full[8*b +: 8] = crc[8*(LANES-1-b) +: 8];
    end

    always_comb begin
        if (narrow) begin
            plain_view  = {{(DATA_W-HALF_W){1'b0}}, crc[HALF_W-1:0]};
            mirror_view = {{(DATA_W-HALF_W){1'b0}}, mir_half};
            swap_view   = {{(DATA_W-HALF_W){1'b0}}, crc[7:0], crc[15:8]};
        end else begin
            plain_view  = crc;
            mirror_view = mir_full;
            swap_view   = swp_full;
        end
    end

endmodule

// File: rtl/crc_accel.sv
module crc_accel
    import crc_accel_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [DATA_W-1:0] POLY32 = 32'h04C1_1DB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [LANES-1:0]  bus_be,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFF_CLR);
    localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(OFF_POLY);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'(OFF_REV);
    localparam logic [ADDR_W-1:0] A_SWAP = ADDR_W'(OFF_SWAP);

    logic [DATA_W-1:0] ctrl_q, ctrl_d;
    logic [HALF_W-1:0] poly_q, poly_d;
    logic [DATA_W-1:0] crc_q,  crc_d;

    acc_e              acc;
    logic [LANES-1:0][7:0] seq;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] folded;
    logic [DATA_W-1:0] plain_view, mirror_view, swap_view;
    logic              narrow;
    logic              auto_hit;
    logic [LANES-1:0]  auto_lane;

    assign narrow = ctrl_q[CB_NARROW];

    // address decode
    always_comb begin
        unique case (bus_addr)
            A_CTRL:  acc = ACC_CTRL;
            A_SET:   acc = ACC_SET;
            A_CLR:   acc = ACC_CLR;
            A_POLY:  acc = ACC_POLY;
            A_DATA:  acc = ACC_DATA;
            A_REV:   acc = ACC_REV;
            A_SWAP:  acc = ACC_SWAP;
            default: acc = ACC_NONE;
        endcase
    end

    crc_input_shaper i_shaper (
        .wdata     (bus_wdata),
        .be        (bus_be),
        .order     (ctrl_q[CB_ORD_LO +: 2]),
        .mirror    (ctrl_q[CB_MIRROR]),
        .byte_mode (ctrl_q[CB_BYTEMODE]),
        .seq       (seq),
        .count     (count)
    );

    crc_fold #(.POLY32(POLY32)) i_fold (
        .crc_in  (crc_q),
        .seq     (seq),
        .count   (count),
        .poly16  (poly_q),
        .narrow  (narrow),
        .crc_out (folded)
    );

    crc_views i_views (
        .crc         (crc_q),
        .narrow      (narrow),
        .plain_view  (plain_view),
        .mirror_view (mirror_view),
        .swap_view   (swap_view)
    );

    // lane whose read re-arms the seed
    always_comb begin
        auto_lane = '0;
        if (!ctrl_q[CB_AUTO_HI])  auto_lane[0] = 1'b1;
        else if (narrow)          auto_lane[1] = 1'b1;
        else                      auto_lane[LANES-1] = 1'b1;
    end

    assign auto_hit = ctrl_q[CB_AUTO] && ((bus_be & auto_lane) != '0) &&
                      (acc == ACC_DATA || acc == ACC_REV || acc == ACC_SWAP);

    // next-state logic
    always_comb begin
        ctrl_d = ctrl_q;
        poly_d = poly_q;
        crc_d  = crc_q;
        if (bus_wr) begin
            unique case (acc)
                ACC_CTRL: begin
                    ctrl_d = bus_wdata & CTRL_MASK;
                    if (bus_wdata[CB_SEED_GO]) crc_d = ctrl_d[CB_SEED_ONE] ? '1 : '0;
                end
                ACC_SET: begin
                    ctrl_d = ctrl_q | (bus_wdata & CTRL_MASK);
                    if (bus_wdata[CB_SEED_GO]) crc_d = ctrl_d[CB_SEED_ONE] ? '1 : '0;
                end
                ACC_CLR:  ctrl_d = ctrl_q & ~bus_wdata;
                ACC_POLY: poly_d = bus_wdata[HALF_W-1:0];
                ACC_DATA: if (ctrl_q[CB_ENABLE]) crc_d = folded;
                ACC_REV, ACC_SWAP, ACC_NONE: ;
            endcase
        end else if (bus_rd && auto_hit) begin
            crc_d = ctrl_q[CB_SEED_ONE] ? '1 : '0;
        end
    end

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            poly_q <= '0;
            crc_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            poly_q <= poly_d;
            crc_q  <= crc_d;
        end
    end

    // read mux
    always_comb begin
        unique case (acc)
            ACC_CTRL, ACC_SET, ACC_CLR: bus_rdata = ctrl_q;
            ACC_POLY: bus_rdata = {{(DATA_W-HALF_W){1'b0}}, poly_q};
            ACC_DATA: bus_rdata = plain_view;
            ACC_REV:  bus_rdata = mirror_view;
            ACC_SWAP: bus_rdata = swap_view;
            ACC_NONE: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/crc_accel_chk.sv
module crc_accel_chk
    import crc_accel_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [LANES-1:0]  bus_be,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] crc_q
);

    // R1
    ctrl_resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_CTRL)) |-> ((bus_rdata & ~CTRL_MASK) == '0));

    // R1
    set_alias_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_SET)) |=>
        (ctrl_q == ($past(ctrl_q) | ($past(bus_wdata) & CTRL_MASK))));

    // R2
    seed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata[CB_SEED_GO] && bus_wdata[CB_SEED_ONE])
        |=> (crc_q == '1));

    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_DATA) && !ctrl_q[CB_ENABLE]) |=> $stable(crc_q));

    // R4
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_NARROW] && bus_addr == ADDR_W'(OFF_DATA)) |-> (bus_rdata[DATA_W-1:HALF_W] == '0));

    // R11
    autoseed_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == ADDR_W'(OFF_DATA) && ctrl_q[CB_AUTO] &&
         !ctrl_q[CB_AUTO_HI] && bus_be[0])
        |=> (crc_q == ($past(ctrl_q[CB_SEED_ONE]) ? '1 : '0)));

endmodule

bind crc_accel crc_accel_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata),
    .ctrl_q    (ctrl_q),
    .crc_q     (crc_q)
);

// File: tb/test_crc_accel.sv
module test_crc_accel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_ctrl = '0;
    logic [15:0] m_poly = '0;
    logic [31:0] m_crc  = '0;

    always #5 clk = ~clk;

    crc_accel i_crc_accel (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_seed();
        return m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0;
    endfunction

    function automatic logic [7:0] m_rev8(input logic [7:0] b);
        logic [7:0] r = '0;
        for (int i = 0; i < 8; i++) if (b[i]) r = r | (8'h80 >> i);
        return r;
    endfunction

    task automatic m_fold(input logic [7:0] b);
        if (m_ctrl[4]) begin
            logic [15:0] r = m_crc[15:0] ^ {b, 8'h00};
            for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ m_poly) : (r << 1);
            m_crc = {16'h0, r};
        end else begin
            logic [31:0] r = m_crc ^ {b, 24'h0};
            for (int k = 0; k < 8; k++) r = r[31] ? ((r << 1) ^ 32'h04C1_1DB7) : (r << 1);
            m_crc = r;
        end
    endtask

    task automatic m_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [7:0] sh [4];
        int src;
        case (a)
            8'h00: begin m_ctrl = d & 32'h6F16; if (d[0]) m_crc = m_seed(); end
            8'h04: begin m_ctrl = m_ctrl | (d & 32'h6F16); if (d[0]) m_crc = m_seed(); end
            8'h08: m_ctrl = m_ctrl & ~d;
            8'h10: m_poly = d[15:0];
            8'h20: if (m_ctrl[2]) begin
                if (m_ctrl[8]) begin
                    m_fold(m_ctrl[9] ? m_rev8(d[7:0]) : d[7:0]);
                end else begin
                    for (int i = 0; i < 4; i++) begin
                        case (m_ctrl[11:10])
                            2'd1: src = i ^ 1;
                            2'd2: src = 3 - i;
                            default: src = i;
                        endcase
                        sh[i] = d[8*src +: 8];
                        if (m_ctrl[9]) sh[i] = m_rev8(sh[i]);
                    end
                    case (be)
                        4'b1111: for (int i = 3; i >= 0; i--) m_fold(sh[i]);
                        4'b0011: begin m_fold(sh[1]); m_fold(sh[0]); end
                        4'b1100: begin m_fold(sh[3]); m_fold(sh[2]); end
                        4'b0001: m_fold(sh[0]);
                        4'b0010: m_fold(sh[1]);
                        4'b0100: m_fold(sh[2]);
                        4'b1000: m_fold(sh[3]);
                        default: ;
                    endcase
                end
            end
            default: ;
        endcase
    endtask

    function automatic logic [31:0] m_view(input logic [7:0] a);
        logic [31:0] v = '0;
        int w = m_ctrl[4] ? 16 : 32;
        case (a)
            8'h00, 8'h04, 8'h08: v = m_ctrl;
            8'h10: v = {16'h0, m_poly};
            8'h20: v = (w == 16) ? {16'h0, m_crc[15:0]} : m_crc;
            8'h30: for (int i = 0; i < w; i++) v[w-1-i] = m_crc[i];
            8'h40: for (int i = 0; i < w / 8; i++) v[8*(w/8-1-i) +: 8] = m_crc[8*i +: 8];
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic m_read(input logic [7:0] a, input logic [3:0] be);
        int lane = !m_ctrl[14] ? 0 : (m_ctrl[4] ? 1 : 3);
        if (m_ctrl[13] && (a == 8'h20 || a == 8'h30 || a == 8'h40) && be[lane])
            m_crc = m_seed();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        m_write(a, d, be);
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    // compare one read port value with the model, then apply its side effects
    task automatic rd(input logic [7:0] a, input logic [3:0] be, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_be = be;
        #1;
        check(bus_rdata, m_view(a), req);
        m_read(a, be);
        @(negedge clk);
        bus_rd = 1'b0; bus_be = '0;
    endtask

    task automatic rd_const(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_be = '0;
        #1;
        check(bus_rdata, exp, req);
    endtask

    task automatic wr_data(input logic [31:0] d, input logic [3:0] be, input string req);
        wr(8'h20, d, be);
        rd(8'h20, 4'b0000, req);
    endtask

    task automatic feed_string();
        for (int i = 0; i < 9; i++) wr(8'h20, 32'h31 + i, 4'b0001);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R12 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd_const(8'h00, 32'h0, "R1 reset control");
        rd_const(8'h20, 32'h0, "R12 reset result");

        // enable, 32-bit, seed ones
        wr(8'h00, 32'h0000_0007, 4'hF);
        rd_const(8'h00, 32'h0000_0006, "R1 seed bit reads zero");
        rd_const(8'h20, 32'hFFFF_FFFF, "R2 seed all ones");

        // R3 check string as bytes
        feed_string();
        rd_const(8'h20, 32'h0376_E6E7, "R3 check string bytes");
        rd(8'h30, 4'b0000, "R10 mirrored view 32");
        rd(8'h40, 4'b0000, "R10 swapped view 32");

        // R5 words then byte, seeded through the set alias
        wr(8'h04, 32'h0000_0001, 4'hF);
        rd_const(8'h20, 32'hFFFF_FFFF, "R2 seed via set alias");
        wr(8'h20, 32'h3132_3334, 4'b1111);
        wr(8'h20, 32'h3536_3738, 4'b1111);
        wr(8'h20, 32'h0000_0039, 4'b0001);
        rd_const(8'h20, 32'h0376_E6E7, "R5 word writes lane3 first");

        // R7 full swap
        wr(8'h04, 32'h0000_0801, 4'hF);
        wr(8'h20, 32'h3433_3231, 4'b1111);
        wr(8'h20, 32'h3837_3635, 4'b1111);
        wr(8'h20, 32'h3900_0000, 4'b0001);
        rd_const(8'h20, 32'h0376_E6E7, "R7 full byte swap");

        // R7 halfword swap
        wr(8'h08, 32'h0000_0C00, 4'hF);
        wr(8'h04, 32'h0000_0401, 4'hF);
        rd(8'h00, 4'b0000, "R1 clear then set alias");
        wr(8'h20, 32'h3231_3433, 4'b1111);
        wr(8'h20, 32'h3635_3837, 4'b1111);
        wr(8'h20, 32'h0000_3900, 4'b0001);
        rd_const(8'h20, 32'h0376_E6E7, "R7 halfword swap");
        wr_data(32'hA5C3_0F81, 4'b0011, "R7 halfword swap on halfword write");
        wr(8'h08, 32'h0000_0400, 4'hF);

        // R8 mirroring, R5 halfwords and single lanes
        wr(8'h04, 32'h0000_0200, 4'hF);
        wr_data(32'hA5C3_0F81, 4'b1111, "R8 mirrored word");
        wr_data(32'h1234_5678, 4'b0011, "R5 low halfword");
        wr_data(32'h1234_5678, 4'b1100, "R5 high halfword");
        wr_data(32'h1234_5678, 4'b0100, "R5 single lane 2");
        wr(8'h08, 32'h0000_0200, 4'hF);
        wr_data(32'h1234_5678, 4'b1000, "R5 single lane 3");
        wr_data(32'hFFFF_FFFF, 4'b0101, "R5 odd enables ignored");
        wr_data(32'hFFFF_FFFF, 4'b0000, "R5 no enables ignored");

        // R6 byte mode
        wr(8'h04, 32'h0000_0100, 4'hF);
        wr_data(32'hDEAD_BEEF, 4'b1111, "R6 byte mode single byte");
        wr(8'h04, 32'h0000_0A00, 4'hF);
        wr_data(32'h1122_3344, 4'b0011, "R6 byte mode ignores order");
        wr(8'h08, 32'h0000_0F00, 4'hF);

        // R9 disabled
        wr(8'h08, 32'h0000_0004, 4'hF);
        wr_data(32'h5555_AAAA, 4'b1111, "R9 disabled write ignored");
        wr(8'h04, 32'h0000_0004, 4'hF);

        // R4 16-bit generator
        wr(8'h10, 32'hFFFF_1021, 4'hF);
        rd(8'h10, 4'b0000, "R12 polynomial readback");
        wr(8'h00, 32'h0000_0017, 4'hF);
        rd_const(8'h20, 32'h0000_FFFF, "R4 narrow seed");
        feed_string();
        rd_const(8'h20, 32'h0000_29B1, "R4 check string narrow");
        rd(8'h30, 4'b0000, "R10 mirrored view 16");
        rd(8'h40, 4'b0000, "R10 swapped view 16");
        wr(8'h10, 32'h0000_8005, 4'hF);
        wr_data(32'h0BAD_F00D, 4'b1111, "R4 word into 16-bit generator");

        // R11 automatic seeding, lane 0
        wr(8'h00, 32'h0000_2016, 4'hF);
        wr_data(32'h0000_00C3, 4'b0001, "R11 load before auto seed");
        rd(8'h30, 4'b0001, "R11 read returns old value");
        rd(8'h20, 4'b0000, "R11 reseeded after lane0 read");
        // lane 1 in 16-bit mode
        wr(8'h04, 32'h0000_4000, 4'hF);
        wr_data(32'h0000_0077, 4'b0001, "R11 narrow load");
        rd(8'h20, 4'b1000, "R11 narrow lane3 read");
        rd(8'h20, 4'b0000, "R11 narrow lane3 no reseed");
        rd(8'h40, 4'b0010, "R11 narrow lane1 read");
        rd(8'h20, 4'b0000, "R11 narrow lane1 reseed");
        // lane 3 in 32-bit mode
        wr(8'h08, 32'h0000_0010, 4'hF);
        wr_data(32'h0000_0042, 4'b0001, "R11 wide load");
        rd(8'h20, 4'b0010, "R11 wide lane1 read");
        rd(8'h20, 4'b0000, "R11 wide lane1 no reseed");
        rd(8'h30, 4'b1000, "R11 wide lane3 read");
        rd(8'h20, 4'b0000, "R11 wide lane3 reseed");
        // zero seed
        wr(8'h00, 32'h0000_2004, 4'hF);
        wr_data(32'h0000_0099, 4'b0001, "R11 load zero seed case");
        rd(8'h40, 4'b0001, "R11 zero seed read");
        rd_const(8'h20, 32'h0, "R11 reseeded to zero");

        // R1 reserved bits, R12 map
        wr(8'h00, 32'hFFFF_FFFF, 4'hF);
        rd_const(8'h00, 32'h0000_6F16, "R1 reserved bits zero");
        rd_const(8'h04, 32'h0000_6F16, "R12 set alias reads control");
        rd_const(8'h50, 32'h0, "R12 unmapped reads zero");
        rd_const(8'h21, 32'h0, "R12 unaligned reads zero");
        wr(8'h0C, 32'hFFFF_FFFF, 4'hF);
        rd(8'h20, 4'b0000, "R12 unmapped write no effect");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule